// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences single transfers for a four-channel DMA controller. Each channel raises a request together with a direction flag. The flag selects a device-to-memory transfer, which is a memory write, or a memory-to-device transfer, which is a memory read. The surrounding register block supplies these values as plain inputs:

- a mode byte for each channel;
- the channel mask bits;
- a command byte;
- the base address and base count of each channel.

The sequencer holds the current address and current count of every channel itself. A channel's current values are loaded from its base values when that channel's load strobe is pulsed. Page bytes are written through a small page port, and the 4-bit offset of each write selects the channel that receives the byte.

In any cycle, the sequencer accepts at most one request: the lowest-numbered eligible channel. It drives the ready bit of that channel for the same cycle, and the accept happens when the ready bit and the valid bit are both high. One cycle later it presents a registered transfer. The transfer carries a done pulse, the channel number, the 24-bit physical address, a read or write strobe and a terminal-count flag. In the same cycle, the status-set and mask-set pulses go to the register block. A channel that is not ready keeps its request pending: a refused request applies back-pressure and nothing is lost. The transfer output has no back-pressure, because each transfer is a single-cycle event.

After every transfer, the current address steps up or down by one and the current count drops by one. When a transfer finds the current count at zero, it is the terminal-count transfer. After it, the channel either reloads its current address and count from the base values (auto-init), or it asks the register block to mask it. The `WORD_MODE` parameter selects a word-wide variant, in which the address is scaled by two.

Top module: `dma_xfer_seq`

## Requirements
- R1: After reset there is no transfer (`xfer_valid`, `xfer_rd`, `xfer_wr` and `xfer_tc` are low). Every current address, current count and page byte is zero.
- R2: A request is not accepted in any of these cases:
  - `cmd` bit 2 is high;
  - the channel's `mask` bit is high;
  - mode bits [3:2] do not match the direction. Memory write (`req_to_mem`=1) needs 2'b01 and memory read (`req_to_mem`=0) needs 2'b10.
- R3: At most one `req_ready` bit is high in a cycle. It belongs to the lowest-numbered channel that is eligible.
- R4: In byte mode the transfer address is {page, current address}. With `WORD_MODE`=1 it is {page[7:1], current address, 1'b0}. Both are 24 bits wide. The address uses the values held before the accept.
- R5: After each transfer without a reload, the current address decrements if mode bit 5 is set and increments otherwise.
- R6: Each transfer decrements the current count. The transfer that finds the count at zero raises `xfer_tc`, so a loaded count N gives N+1 transfers.
- R7: At terminal count with mode bit 4 set, the current address and current count reload from the base values.
- R8: At terminal count with mode bit 4 clear, `mask_set` pulses for that channel. The channel is not accepted in the cycle in which that pulse is shown.
- R9: At terminal count, `status_set` pulses for that channel alongside the transfer. It is zero otherwise.
- R10: A page write at offset 7 loads channel 0, offset 3 loads channel 1, offset 1 loads channel 2 and offset 2 loads channel 3. Writes at any other offset change nothing. A write takes effect for accepts in later cycles.
- R11: An accept in one cycle gives `xfer_valid` in the next cycle, and only then. That cycle carries the channel number and exactly one strobe: `xfer_wr` for a memory write or `xfer_rd` for a memory read.
- R12: A `cur_load` pulse copies a channel's base address and base count into its current registers. That channel is not accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCH | Per-channel transfer request |
| req_to_mem | input | NCH | Per-channel direction: 1 = memory write, 0 = memory read |
| req_ready | output | NCH | One-hot accept for the current cycle |
| cmd | input | 8 | Command byte; bit 2 disables all transfers |
| mask | input | NCH | Per-channel mask bits |
| mode | input | NCH x 8 | Per-channel mode byte: [3:2] type, [4] auto-init, [5] decrement |
| base_addr | input | NCH x AW | Per-channel base address |
| base_cnt | input | NCH x CW | Per-channel base count |
| cur_load | input | NCH | Copy base values into current registers |
| page_we | input | 1 | Page port write strobe |
| page_off | input | 4 | Page port offset |
| page_wdata | input | PW | Page byte written |
| cur_addr | output | NCH x AW | Current address of each channel |
| cur_cnt | output | NCH x CW | Current count of each channel |
| xfer_valid | output | 1 | Done pulse for the transfer accepted in the previous cycle |
| xfer_chan | output | log2(NCH) | Channel of that transfer |
| xfer_addr | output | PW+AW | Physical address of that transfer |
| xfer_rd | output | 1 | Memory read strobe |
| xfer_wr | output | 1 | Memory write strobe |
| xfer_tc | output | 1 | Terminal count reached on that transfer |
| status_set | output | NCH | Pulse: set the channel's status bit |
| mask_set | output | NCH | Pulse: set the channel's mask bit |

## Verification
A directed run starts with a transfer before any page write, which shows whether the page bytes clear to zero. It then writes the page port at each routed offset and at one unused offset, which shows whether the routing is right and whether stray writes are dropped. Next, all four channels request together and pass through terminal count. This separates the lowest-number priority from the reload and self-mask paths, and it shows whether a channel that just masked itself is locked out before the register block's mask arrives. Last comes a stream of random requests with a fixed seed, with occasional reloads, mode changes, mask clears and disable pulses. Against a bench reference model, this stream tells apart count underflow, direction mismatches and stepping in either direction, in both the byte-wide and the word-wide address forms.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  // Field positions inside the per-channel mode byte and the command byte
  localparam int MODE_TYPE_LO = 2;
  localparam int MODE_AUTO    = 4;
  localparam int MODE_DEC     = 5;
  localparam int CMD_DISABLE  = 2;

  typedef enum logic [1:0] {
    XT_VERIFY  = 2'b00,
    XT_MEM_WR  = 2'b01,
    XT_MEM_RD  = 2'b10,
    XT_ILLEGAL = 2'b11
  } xfer_type_e;

  typedef struct packed {
    logic       hit;
    logic [1:0] chan;
  } page_route_t;

  // Page port offset to channel routing
  function automatic page_route_t page_route(input logic [3:0] off);
    page_route_t r;
    r = '0;
    unique case (off)
      4'd7:    begin r.hit = 1'b1; r.chan = 2'd0; end
      4'd3:    begin r.hit = 1'b1; r.chan = 2'd1; end
      4'd1:    begin r.hit = 1'b1; r.chan = 2'd2; end
      4'd2:    begin r.hit = 1'b1; r.chan = 2'd3; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dma_page_bank.sv
module dma_page_bank
  import dma_xfer_pkg::*;
#(
  parameter int NCH = 4,
  parameter int PW  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [3:0]              off,
  input  logic [PW-1:0]           wdata,
  output logic [NCH-1:0][PW-1:0]  pages
);

  page_route_t route;
  assign route = page_route(off);

  for (genvar c = 0; c < NCH; c++) begin : g_page
    logic hit_c;
    assign hit_c = we && route.hit && (route.chan == 2'(c));

    always_ff @(posedge clk) begin
      if (!rst_n)      pages[c] <= '0;
      else if (hit_c)  pages[c] <= wdata;
    end
  end

endmodule

// File: rtl/dma_chan_ctr.sv
module dma_chan_ctr #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic          auto_en,
  input  logic          dec_en,
  input  logic [AW-1:0] base_a,
  input  logic [CW-1:0] base_c,
  output logic [AW-1:0] cur_a,
  output logic [CW-1:0] cur_c,
  output logic          at_tc
);

  // The transfer that finds the count at zero is the last one
  assign at_tc = (cur_c == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_a <= '0;
      cur_c <= '0;
    end else if (load) begin
      cur_a <= base_a;
      cur_c <= base_c;
    end else if (step) begin
      if (at_tc && auto_en) begin
        cur_a <= base_a;
        cur_c <= base_c;
      end else begin
        cur_a <= dec_en ? (cur_a - AW'(1)) : (cur_a + AW'(1));
        cur_c <= cur_c - CW'(1);
      end
    end
  end

endmodule

// File: rtl/dma_xfer_pick.sv
module dma_xfer_pick #(
  parameter int NCH = 4
) (
  input  logic [NCH-1:0]         elig,
  output logic [NCH-1:0]         grant,
  output logic [$clog2(NCH)-1:0] gidx,
  output logic                   any
);

  localparam int IW = $clog2(NCH);

  // Fixed priority: channel 0 first
  always_comb begin
    grant = '0;
    gidx  = '0;
    any   = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (elig[i] && !any) begin
        any      = 1'b1;
        gidx     = IW'(i);
        grant[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dma_xfer_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 16,
  parameter int CW        = 16,
  parameter int PW        = 8,
  parameter bit WORD_MODE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          req_valid,
  input  logic [NCH-1:0]          req_to_mem,
  output logic [NCH-1:0]          req_ready,
  input  logic [7:0]              cmd,
  input  logic [NCH-1:0]          mask,
  input  logic [NCH-1:0][7:0]     mode,
  input  logic [NCH-1:0][AW-1:0]  base_addr,
  input  logic [NCH-1:0][CW-1:0]  base_cnt,
  input  logic [NCH-1:0]          cur_load,
  input  logic                    page_we,
  input  logic [3:0]              page_off,
  input  logic [PW-1:0]           page_wdata,
  output logic [NCH-1:0][AW-1:0]  cur_addr,
  output logic [NCH-1:0][CW-1:0]  cur_cnt,
  output logic                    xfer_valid,
  output logic [$clog2(NCH)-1:0]  xfer_chan,
  output logic [PW+AW-1:0]        xfer_addr,
  output logic                    xfer_rd,
  output logic                    xfer_wr,
  output logic                    xfer_tc,
  output logic [NCH-1:0]          status_set,
  output logic [NCH-1:0]          mask_set
);

  localparam int IW  = $clog2(NCH);
  localparam int XAW = PW + AW;

  logic [NCH-1:0]         elig;
  logic [NCH-1:0]         grant;
  logic [NCH-1:0]         at_tc;
  logic [NCH-1:0]         auto_vec;
  logic [IW-1:0]          gidx;
  logic                   any;
  logic [NCH-1:0][PW-1:0] pages;
  logic [PW-1:0]          sel_pg;
  logic [AW-1:0]          sel_a;
  logic [XAW-1:0]         addr_now;

  // Eligibility: enabled, unmasked, not self-masking, not reloading, type matches
  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      elig[c] = req_valid[c] && !cmd[CMD_DISABLE] && !mask[c] && !mask_set[c] &&
                !cur_load[c] &&
                (mode[c][MODE_TYPE_LO +: 2] ==
                 (req_to_mem[c] ? 2'(XT_MEM_WR) : 2'(XT_MEM_RD)));
      auto_vec[c] = mode[c][MODE_AUTO];
    end
  end

  dma_xfer_pick #(.NCH(NCH)) u_pick (
    .elig  (elig),
    .grant (grant),
    .gidx  (gidx),
    .any   (any)
  );

  assign req_ready = grant;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dma_chan_ctr #(.AW(AW), .CW(CW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (cur_load[c]),
      .step    (grant[c]),
      .auto_en (mode[c][MODE_AUTO]),
      .dec_en  (mode[c][MODE_DEC]),
      .base_a  (base_addr[c]),
      .base_c  (base_cnt[c]),
      .cur_a   (cur_addr[c]),
      .cur_c   (cur_cnt[c]),
      .at_tc   (at_tc[c])
    );
  end

  dma_page_bank #(.NCH(NCH), .PW(PW)) u_pages (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (page_we),
    .off   (page_off),
    .wdata (page_wdata),
    .pages (pages)
  );

  assign sel_pg = pages[gidx];
  assign sel_a  = cur_addr[gidx];

  if (WORD_MODE) begin : g_word
    assign addr_now = {sel_pg[PW-1:1], sel_a, 1'b0};
  end else begin : g_byte
    assign addr_now = {sel_pg, sel_a};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xfer_valid <= 1'b0;
      xfer_chan  <= '0;
      xfer_addr  <= '0;
      xfer_rd    <= 1'b0;
      xfer_wr    <= 1'b0;
      xfer_tc    <= 1'b0;
      status_set <= '0;
      mask_set   <= '0;
    end else begin
      xfer_valid <= any;
      xfer_chan  <= gidx;
      xfer_addr  <= any ? addr_now : '0;
      xfer_rd    <= any && !req_to_mem[gidx];
      xfer_wr    <= any && req_to_mem[gidx];
      xfer_tc    <= any && at_tc[gidx];
      status_set <= grant & at_tc;
      mask_set   <= grant & at_tc & ~auto_vec;
    end
  end

endmodule

// File: rtl/dma_xfer_seq_chk.sv
module dma_xfer_seq_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] req_ready,
  input logic [NCH-1:0] mask,
  input logic [7:0]     cmd,
  input logic           xfer_valid,
  input logic           xfer_rd,
  input logic           xfer_wr,
  input logic           xfer_tc,
  input logic [NCH-1:0] status_set,
  input logic [NCH-1:0] mask_set
);

  a_r3_single_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  a_r2_disable_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd[2] |-> (req_ready == '0));

  a_r2_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_ready & mask) == '0));

  a_r11_accept_gives_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_ready) |=> xfer_valid);

  a_r11_idle_gives_nothing: assert property (@(posedge clk) disable iff (!rst_n)
    !(|req_ready) |=> !xfer_valid);

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_rd != xfer_wr));

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |-> !(xfer_rd || xfer_wr || xfer_tc));

  a_r9_status_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_set) |-> (xfer_valid && xfer_tc && $onehot(status_set)));

  a_r8_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    (|mask_set) |-> ((req_ready & mask_set) == '0));

  a_r8_mask_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_set & ~status_set) == '0));

endmodule

bind dma_xfer_seq dma_xfer_seq_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .mask       (mask),
  .cmd        (cmd),
  .xfer_valid (xfer_valid),
  .xfer_rd    (xfer_rd),
  .xfer_wr    (xfer_wr),
  .xfer_tc    (xfer_tc),
  .status_set (status_set),
  .mask_set   (mask_set)
);

// File: tb/dma_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module dma_xfer_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]        req_v = '0, to_mem = '0, mask_drv = '0, ld = '0;
  logic [7:0]        cmd_d = '0;
  logic [3:0][7:0]   mode_d = '0;
  logic [3:0][15:0]  ba = '0, bc = '0;
  logic              pg_we = 1'b0;
  logic [3:0]        pg_off = '0;
  logic [7:0]        pg_d = '0;

  logic [3:0]        rdy, sts, mst;
  logic [3:0][15:0]  cura, curc;
  logic              xv, xr, xw, xt;
  logic [1:0]        xch;
  logic [23:0]       xa;

  logic [3:0]        w_rdy, w_sts, w_mst;
  logic [3:0][15:0]  w_cura, w_curc;
  logic              w_xv, w_xr, w_xw, w_xt;
  logic [1:0]        w_xch;
  logic [23:0]       w_xa;

  dma_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v), .req_to_mem(to_mem), .req_ready(rdy),
    .cmd(cmd_d), .mask(mask_drv), .mode(mode_d), .base_addr(ba), .base_cnt(bc),
    .cur_load(ld), .page_we(pg_we), .page_off(pg_off), .page_wdata(pg_d),
    .cur_addr(cura), .cur_cnt(curc), .xfer_valid(xv), .xfer_chan(xch), .xfer_addr(xa),
    .xfer_rd(xr), .xfer_wr(xw), .xfer_tc(xt), .status_set(sts), .mask_set(mst));

  dma_xfer_seq #(.WORD_MODE(1'b1)) dut_w (
    .clk(clk), .rst_n(rst_n), .req_valid(req_v), .req_to_mem(to_mem), .req_ready(w_rdy),
    .cmd(cmd_d), .mask(mask_drv), .mode(mode_d), .base_addr(ba), .base_cnt(bc),
    .cur_load(ld), .page_we(pg_we), .page_off(pg_off), .page_wdata(pg_d),
    .cur_addr(w_cura), .cur_cnt(w_curc), .xfer_valid(w_xv), .xfer_chan(w_xch),
    .xfer_addr(w_xa), .xfer_rd(w_xr), .xfer_wr(w_xw), .xfer_tc(w_xt),
    .status_set(w_sts), .mask_set(w_mst));

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Reference model state
  logic [3:0][15:0] m_a = '0, m_c = '0;
  logic [3:0][7:0]  m_pg = '0;
  logic [3:0]       m_mset = '0;
  logic [3:0]       pend = '0;

  logic        e_valid = 1'b0, e_rd = 1'b0, e_wr = 1'b0, e_tc = 1'b0;
  logic [1:0]  e_chan = '0;
  logic [23:0] e_addr = '0, e_addrw = '0;
  logic [3:0]  e_stat = '0, e_mset = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int route_chan(input logic [3:0] off);
    case (off)
      4'd7: return 0;
      4'd3: return 1;
      4'd1: return 2;
      4'd2: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit eligible(input int c);
    logic [1:0] want;
    want = to_mem[c] ? 2'b01 : 2'b10;
    return req_v[c] && !cmd_d[2] && !mask_drv[c] && !m_mset[c] && !ld[c] &&
           (mode_d[c][3:2] == want);
  endfunction

  // Called at a falling edge with inputs set; runs one cycle and checks it
  task automatic step();
    int g;
    logic [3:0] eg;
    #1;
    g = -1;
    eg = '0;
    for (int c = 3; c >= 0; c--) if (eligible(c)) g = c;
    if (g >= 0) eg[g] = 1'b1;
    chk(rdy == eg, "R3 R2 R8 R12 accept", 64'(rdy), 64'(eg));

    e_valid = (g >= 0);
    e_stat = '0; e_mset = '0; e_rd = 1'b0; e_wr = 1'b0; e_tc = 1'b0;
    e_chan = '0; e_addr = '0; e_addrw = '0;
    if (g >= 0) begin
      e_chan  = 2'(g);
      e_addr  = {m_pg[g], m_a[g]};
      e_addrw = {m_pg[g][7:1], m_a[g], 1'b0};
      e_wr    = to_mem[g];
      e_rd    = !to_mem[g];
      e_tc    = (m_c[g] == 16'd0);
      if (e_tc) begin
        e_stat[g] = 1'b1;
        e_mset[g] = !mode_d[g][4];
      end
    end
    for (int c = 0; c < 4; c++) begin
      if (ld[c]) begin
        m_a[c] = ba[c]; m_c[c] = bc[c];
      end else if (g == c) begin
        if (e_tc && mode_d[c][4]) begin
          m_a[c] = ba[c]; m_c[c] = bc[c];
        end else begin
          m_a[c] = mode_d[c][5] ? m_a[c] - 16'd1 : m_a[c] + 16'd1;
          m_c[c] = m_c[c] - 16'd1;
        end
      end
    end
    if (pg_we && route_chan(pg_off) >= 0) m_pg[route_chan(pg_off)] = pg_d;
    m_mset = e_mset;

    @(posedge clk);
    @(negedge clk);
    chk(xv == e_valid, "R11 done pulse", 64'(xv), 64'(e_valid));
    if (e_valid) begin
      chk(xch == e_chan, "R3 channel", 64'(xch), 64'(e_chan));
      chk(xa == e_addr, "R4 R10 byte address", 64'(xa), 64'(e_addr));
      chk(w_xa == e_addrw, "R4 word address", 64'(w_xa), 64'(e_addrw));
      chk({xr, xw} == {e_rd, e_wr}, "R11 strobes", 64'({xr, xw}), 64'({e_rd, e_wr}));
      chk(xt == e_tc, "R6 terminal count", 64'(xt), 64'(e_tc));
    end
    chk(sts == e_stat, "R9 status pulse", 64'(sts), 64'(e_stat));
    chk(mst == e_mset, "R8 mask pulse", 64'(mst), 64'(e_mset));
    chk(cura == m_a, "R5 R7 R12 current address", cura, m_a);
    chk(curc == m_c, "R6 R7 R12 current count", curc, m_c);
    // Register block applies mask requests one cycle after it sees them
    mask_drv = mask_drv | pend;
    pend = mst;
  endtask

  task automatic idle_inputs();
    req_v = '0; ld = '0; pg_we = 1'b0; cmd_d = '0;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(!xv && !xr && !xw && !xt, "R1 outputs idle", 64'({xv, xr, xw, xt}), 64'(0));
    chk(cura == '0 && curc == '0, "R1 current regs zero", cura | curc, 64'(0));

    // Configure channels and load current registers (R12)
    mode_d[0] = 8'h04; ba[0] = 16'h1000; bc[0] = 16'd1;
    mode_d[1] = 8'h28; ba[1] = 16'h2000; bc[1] = 16'd2;
    mode_d[2] = 8'h14; ba[2] = 16'h3000; bc[2] = 16'd0;
    mode_d[3] = 8'h08; ba[3] = 16'h4000; bc[3] = 16'd1;
    ld = 4'hF; req_v = 4'h1; to_mem = 4'h1;
    step();                               // R12: loading channel is refused
    idle_inputs();

    // R1 page zero: first transfer before any page write
    req_v = 4'h1; to_mem = 4'h1;
    step();
    idle_inputs();
    step();

    // R10 page routing, including an unused offset
    pg_we = 1'b1;
    pg_off = 4'd1; pg_d = 8'hA5; step();
    pg_off = 4'd2; pg_d = 8'h22; step();
    pg_off = 4'd3; pg_d = 8'h11; step();
    pg_off = 4'd7; pg_d = 8'h3C; step();
    pg_off = 4'd5; pg_d = 8'hFF; step();
    pg_off = 4'd0; pg_d = 8'hEE; step();
    pg_we = 1'b0;

    // R3 priority, R6 count, R8 self-mask, R7 auto-init, R5 decrement
    to_mem = 4'b0101;
    for (int k = 0; k < 10; k++) begin
      req_v = 4'hF;
      step();
    end
    idle_inputs();

    // R2 refusals: wrong type, disable bit, mask bit
    mask_drv = '0; m_mset = '0;
    req_v = 4'b1000; to_mem = 4'b1000; step();
    req_v = 4'hF; to_mem = 4'b0101; cmd_d = 8'h04; step();
    cmd_d = '0; mask_drv = 4'b0111; step();
    mask_drv = '0; idle_inputs(); step();

    // Random phase
    for (int it = 0; it < 3000; it++) begin
      for (int c = 0; c < 4; c++) begin
        if ($urandom % 40 == 0) begin
          mode_d[c] = 8'($urandom);
          ba[c] = 16'($urandom);
          bc[c] = 16'($urandom % 4);
        end
        to_mem[c] = (mode_d[c][3:2] == 2'b01) ^ ($urandom % 5 == 0);
      end
      req_v  = 4'($urandom);
      ld     = ($urandom % 16 == 0) ? 4'($urandom) : 4'h0;
      pg_we  = ($urandom % 8 == 0);
      pg_off = 4'($urandom);
      pg_d   = 8'($urandom);
      cmd_d  = ($urandom % 20 == 0) ? 8'h04 : 8'h00;
      if ($urandom % 6 == 0) mask_drv = mask_drv & ~(4'b0001 << ($urandom % 4));
      step();
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule